// File: doc/BRIEF.md
# Multi-Mode Barrel Shift Unit

This unit performs one 32-bit shift per accepted instruction. The opcode picks one of four modes: logical right, arithmetic right, logical left, or left rotate. The amount comes from a 5-bit count field in the instruction word. When that field is zero, the amount comes from the low five bits of the value read from register rc. A field of zero therefore does not mean "shift by nothing".

The datapath is a logarithmic shifter with one stage per bit of the count, moving by 1, 2, 4, 8 and 16 positions. The result is registered, so each instruction costs one cycle of latency. Alongside the result, the unit raises a write-back request naming destination register ra. It raises this request only when the opcode is one of the four shift opcodes.

Top module: `shift_unit`

## Requirements
- R1: The count is instruction bits 4..0 when that field is nonzero; when the field is zero the count is bits 4..0 of `rc_val`, and all upper bits of `rc_val` are ignored.
- R2: Opcode 26 (instruction bits 31..27) shifts `rb_val` right by the count, filling the vacated high bits with zeros.
- R3: Opcode 27 shifts `rb_val` right by the count, filling the vacated high bits with copies of bit 31; 0x97EAEC16 shifted by 13 gives 0xFFFCBF57.
- R4: Opcode 28 shifts `rb_val` left by the count, filling the vacated low bits with zeros.
- R5: Opcode 29 rotates `rb_val` left by the count; the bits leaving at the top re-enter at the bottom, so the number of ones is preserved.
- R6: A selected count of zero (field zero and `rc_val` bits 4..0 zero) returns `rb_val` unchanged in all four modes.
- R7: `out_valid` and the result appear on the clock edge after the edge that sampled `in_valid` high; a cycle with `in_valid` low yields `out_valid`, `wr_en`, `wr_reg` and `result` all zero one cycle later.
- R8: `wr_en` is raised only for valid instructions with opcode 26 to 29, with `wr_reg` equal to instruction bits 26..22; for any other opcode `wr_en`, `wr_reg` and `result` are zero while `out_valid` still follows `in_valid`.
- R9: While `rst_n` is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Instruction and operands are present this cycle |
| instr | input | 32 | Instruction word (opcode 31..27, ra 26..22, count 4..0) |
| rb_val | input | 32 | Operand to be shifted |
| rc_val | input | 32 | Register value supplying the count when the field is zero |
| out_valid | output | 1 | Registered result is present |
| wr_en | output | 1 | Write-back request for register ra |
| wr_reg | output | 5 | Destination register index |
| result | output | 32 | Shifted value |

## Verification
The bench builds the unit with its default 32-bit data width. This gives five shifter stages, so every count from 0 to 31 is reachable through both the count field and the register. The fixed vectors cover the worked arithmetic example and the zero-count corner in each mode. They also check a count register whose upper bits are set, and opcodes just outside the shift range. Several hundred random instructions then exercise every combination of stage enables in all four modes.

// File: rtl/shift_pkg.sv
package shift_pkg;

    localparam int INSTR_W  = 32;
    localparam int OPC_MSB  = 31;
    localparam int OPC_W    = 5;
    localparam int DEST_LSB = 22;
    localparam int REG_W    = 5;

    localparam logic [OPC_W-1:0] OPC_SHR_LOG = 5'd26;
    localparam logic [OPC_W-1:0] OPC_SHR_ARI = 5'd27;
    localparam logic [OPC_W-1:0] OPC_SHL_LOG = 5'd28;
    localparam logic [OPC_W-1:0] OPC_ROT_LFT = 5'd29;

    typedef enum logic [1:0] {
        MODE_LSR = 2'd0,
        MODE_ASR = 2'd1,
        MODE_LSL = 2'd2,
        MODE_ROL = 2'd3
    } shift_mode_e;

endpackage

// File: rtl/shift_decode.sv
module shift_decode
    import shift_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic [INSTR_W-1:0] instr,
    input  logic [CNT_W-1:0]   rc_low,
    output logic               is_shift,
    output shift_mode_e        mode,
    output logic [CNT_W-1:0]   amount,
    output logic [REG_W-1:0]   dest
);

    logic [OPC_W-1:0] opcode;
    logic [CNT_W-1:0] imm_cnt;
    logic [OPC_W-1:0] mode_off;
    logic             unused_fields;

    assign opcode        = instr[OPC_MSB -: OPC_W];
    assign imm_cnt       = instr[CNT_W-1:0];
    assign dest          = instr[DEST_LSB +: REG_W];
    assign unused_fields = ^instr[DEST_LSB-1:CNT_W];

    always_comb begin
        is_shift = (opcode >= OPC_SHR_LOG) && (opcode <= OPC_ROT_LFT);
        mode_off = opcode - OPC_SHR_LOG;
        mode     = shift_mode_e'(mode_off[1:0]);
        amount   = (imm_cnt != '0) ? imm_cnt : rc_low;
    end

endmodule

// File: rtl/shift_stage.sv
module shift_stage
    import shift_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int AMT    = 1
) (
    input  logic [DATA_W-1:0] din,
    input  logic              en,
    input  shift_mode_e       mode,
    output logic [DATA_W-1:0] dout
);

    logic [DATA_W-1:0] moved;
    logic              sign_bit;

    assign sign_bit = din[DATA_W-1];

    always_comb begin
        unique case (mode)
            MODE_LSR: moved = {{AMT{1'b0}}, din[DATA_W-1:AMT]};
            MODE_ASR: moved = {{AMT{sign_bit}}, din[DATA_W-1:AMT]};
            MODE_LSL: moved = {din[DATA_W-1-AMT:0], {AMT{1'b0}}};
            MODE_ROL: moved = {din[DATA_W-1-AMT:0], din[DATA_W-1:DATA_W-AMT]};
            default:  moved = din;
        endcase
        dout = en ? moved : din;
    end

endmodule

// File: rtl/shift_core.sv
module shift_core
    import shift_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int CNT_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] operand,
    input  logic [CNT_W-1:0]  amount,
    input  shift_mode_e       mode,
    output logic [DATA_W-1:0] shifted
);

    logic [DATA_W-1:0] level [CNT_W+1];

    assign level[0] = operand;

    for (genvar k = 0; k < CNT_W; k++) begin : g_level
        shift_stage #(
            .DATA_W(DATA_W),
            .AMT   (1 << k)
        ) u_stage (
            .din (level[k]),
            .en  (amount[k]),
            .mode(mode),
            .dout(level[k+1])
        );
    end

    assign shifted = level[CNT_W];

endmodule

// File: rtl/shift_unit.sv
module shift_unit
    import shift_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int CNT_W = $clog2(DATA_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [INSTR_W-1:0] instr,
    input  logic [DATA_W-1:0]  rb_val,
    input  logic [DATA_W-1:0]  rc_val,
    output logic               out_valid,
    output logic               wr_en,
    output logic [REG_W-1:0]   wr_reg,
    output logic [DATA_W-1:0]  result
);

    typedef struct packed {
        logic              valid;
        logic              wr;
        logic [REG_W-1:0]  dst;
        logic [DATA_W-1:0] data;
    } out_state_t;

    out_state_t  st_d, st_q;
    logic        dec_shift;
    shift_mode_e dec_mode;
    logic [CNT_W-1:0] dec_amount;
    logic [REG_W-1:0] dec_dest;
    logic [DATA_W-1:0] core_out;
    logic        unused_rc_high;

    assign unused_rc_high = ^rc_val[DATA_W-1:CNT_W];

    shift_decode #(.CNT_W(CNT_W)) u_decode (
        .instr   (instr),
        .rc_low  (rc_val[CNT_W-1:0]),
        .is_shift(dec_shift),
        .mode    (dec_mode),
        .amount  (dec_amount),
        .dest    (dec_dest)
    );

    shift_core #(.DATA_W(DATA_W)) u_core (
        .operand(rb_val),
        .amount (dec_amount),
        .mode   (dec_mode),
        .shifted(core_out)
    );

    always_comb begin
        st_d       = '0;
        st_d.valid = in_valid;
        if (in_valid && dec_shift) begin
            st_d.wr   = 1'b1;
            st_d.dst  = dec_dest;
            st_d.data = core_out;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.valid;
    assign wr_en     = st_q.wr;
    assign wr_reg    = st_q.dst;
    assign result    = st_q.data;

endmodule

// File: rtl/shift_unit_chk.sv
module shift_unit_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [31:0]       instr,
    input logic [DATA_W-1:0] rb_val,
    input logic [DATA_W-1:0] rc_val,
    input logic              out_valid,
    input logic              wr_en,
    input logic [4:0]        wr_reg,
    input logic [DATA_W-1:0] result
);

    // R7
    valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R7
    bubble_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !wr_en && result == '0));

    // R8
    write_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && instr[31:27] >= 5'd26 && instr[31:27] <= 5'd29)
        |=> (wr_en && wr_reg == $past(instr[26:22])));

    // R8
    no_write_other_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (instr[31:27] < 5'd26 || instr[31:27] > 5'd29))
        |=> (!wr_en && result == '0));

    // R6
    zero_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && instr[4:0] == 5'd0 && rc_val[4:0] == 5'd0 &&
         instr[31:27] >= 5'd26 && instr[31:27] <= 5'd29)
        |=> (result == $past(rb_val)));

    // R5
    rotate_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && instr[31:27] == 5'd29)
        |=> ($countones(result) == $countones($past(rb_val))));

    // R9
    always_comb begin
        if (!rst_n) begin
            reset_quiet_chk: assert (out_valid == 1'b0 || $isunknown(out_valid));
        end
    end

endmodule

bind shift_unit shift_unit_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .instr    (instr),
    .rb_val   (rb_val),
    .rc_val   (rc_val),
    .out_valid(out_valid),
    .wr_en    (wr_en),
    .wr_reg   (wr_reg),
    .result   (result)
);

// File: tb/shift_unit_test.sv
`timescale 1ns/1ps
module shift_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] rb_val = '0;
    logic [31:0] rc_val = '0;
    logic        out_valid, wr_en;
    logic [4:0]  wr_reg;
    logic [31:0] result;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    typedef struct packed {
        logic        v;
        logic        w;
        logic [4:0]  r;
        logic [31:0] d;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];

    always #2.5 clk = ~clk;

    shift_unit uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
        .rb_val(rb_val), .rc_val(rc_val), .out_valid(out_valid),
        .wr_en(wr_en), .wr_reg(wr_reg), .result(result)
    );

    function automatic logic [31:0] mk(input int op, input int ra, input int cnt);
        logic [31:0] w;
        w = '0;
        w[31:27] = op[4:0];
        w[26:22] = ra[4:0];
        w[4:0]   = cnt[4:0];
        return w;
    endfunction

    function automatic exp_t model(input logic v, input logic [31:0] ins,
                                   input logic [31:0] b, input logic [31:0] c);
        exp_t e;
        int   n;
        int   op;
        e = '0;
        e.v = v;
        if (!v) return e;
        n  = (ins[4:0] != 0) ? int'(ins[4:0]) : int'(c[4:0]);
        op = int'(ins[31:27]);
        if (op < 26 || op > 29) return e;
        e.w = 1'b1;
        e.r = ins[26:22];
        case (op)
            26: e.d = b >> n;
            27: e.d = $signed(b) >>> n;
            28: e.d = b << n;
            default: e.d = (n == 0) ? b : ((b << n) | (b >> (32 - n)));
        endcase
        return e;
    endfunction

    task automatic compare_front();
        exp_t  e;
        string t;
        if (exp_q.size() == 0) return;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (out_valid !== e.v || wr_en !== e.w || wr_reg !== e.r || result !== e.d) begin
            errors++;
            $display("FAIL %s: got v=%0b w=%0b r=%0d d=%h, expected v=%0b w=%0b r=%0d d=%h",
                     t, out_valid, wr_en, wr_reg, result, e.v, e.w, e.r, e.d);
        end
    endtask

    task automatic step(input logic v, input logic [31:0] ins,
                        input logic [31:0] b, input logic [31:0] c, input string tag);
        @(negedge clk);
        compare_front();
        in_valid = v;
        instr    = ins;
        rb_val   = b;
        rc_val   = c;
        exp_q.push_back(model(v, ins, b, c));
        tag_q.push_back(tag);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: got no completion, expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        // R9 outputs held at zero in reset
        if (out_valid !== 1'b0 || wr_en !== 1'b0 || wr_reg !== 5'd0 || result !== 32'd0) begin
            errors++;
            $display("FAIL R9: got v=%0b w=%0b r=%0d d=%h, expected all zero",
                     out_valid, wr_en, wr_reg, result);
        end
        rst_n = 1'b1;

        // R3 worked example
        step(1'b1, mk(27, 1, 13), 32'h97EAEC16, 32'h0, "R3");
        step(1'b1, mk(27, 2, 31), 32'h80000000, 32'h0, "R3");
        step(1'b1, mk(26, 3, 4),  32'h97EAEC16, 32'h0, "R2");
        step(1'b1, mk(26, 4, 31), 32'hFFFFFFFF, 32'h0, "R2");
        step(1'b1, mk(28, 5, 8),  32'h12345678, 32'h0, "R4");
        step(1'b1, mk(28, 6, 31), 32'h00000003, 32'h0, "R4");
        step(1'b1, mk(29, 7, 4),  32'hF0000001, 32'h0, "R5");
        step(1'b1, mk(29, 8, 31), 32'h00000001, 32'h0, "R5");
        // R1 count from rc, upper rc bits ignored
        step(1'b1, mk(26, 9, 0),  32'h80000000, 32'h00000007, "R1");
        step(1'b1, mk(28, 10, 0), 32'h00000001, 32'hFFFFFFE3, "R1");
        step(1'b1, mk(27, 11, 0), 32'h80000000, 32'h0000001F, "R1");
        // R1 nonzero field wins over rc
        step(1'b1, mk(26, 12, 1), 32'h00000100, 32'h00000010, "R1");
        // R6 zero count in each mode
        for (int m = 26; m <= 29; m++)
            step(1'b1, mk(m, 13, 0), 32'hA5C3_0F96, 32'hFFFFFFE0, "R6");
        // R7 bubble, then back to back
        step(1'b0, mk(26, 14, 3), 32'hFFFFFFFF, 32'h0, "R7");
        step(1'b1, mk(29, 15, 16), 32'h1234ABCD, 32'h0, "R7");
        step(1'b1, mk(26, 31, 1),  32'h00000002, 32'h0, "R7");
        // R8 opcodes just outside range and others
        step(1'b1, mk(25, 16, 2), 32'hFFFFFFFF, 32'h0, "R8");
        step(1'b1, mk(30, 17, 2), 32'hFFFFFFFF, 32'h0, "R8");
        step(1'b1, mk(12, 18, 2), 32'hFFFFFFFF, 32'h0, "R8");
        step(1'b1, mk(31, 19, 0), 32'hFFFFFFFF, 32'h3, "R8");
        // random sweep over all modes and counts
        for (int i = 0; i < 400; i++) begin
            logic [31:0] ins;
            int op;
            op  = 24 + int'($urandom_range(0, 7));
            ins = $urandom;
            ins[31:27] = op[4:0];
            if (($urandom & 3) == 0) ins[4:0] = 5'd0;
            step(($urandom & 7) != 0, ins, $urandom, $urandom,
                 (op == 26) ? "R2" : (op == 27) ? "R3" : (op == 28) ? "R4" :
                 (op == 29) ? "R5" : "R8");
        end
        step(1'b0, 32'h0, 32'h0, 32'h0, "R7");
        @(negedge clk);
        compare_front();
        finish_run();
    end

endmodule